// File: doc/BRIEF.md
# Memory Error Event Counter Bank

This block keeps statistics on memory errors for one memory controller. Each cycle it may receive one error report. A report says whether the error was corrected or uncorrected, whether its location is known, and the channel and module slot it hit. The block keeps a corrected and an uncorrected counter for every module. It also keeps controller-wide totals for each type and a separate pair of totals for reports that carry no usable location. A coarser bank of counters, one per module slot, merges all channels: a report on slot N counts in coarse counter N whichever channel it came from. An elapsed-time counter gives the whole seconds since the counters were last cleared.

Every counter saturates and does not wrap. A clear strobe zeroes all counters and restarts the time count. A registered read port returns any counter by address. The logging enables only gate a one-cycle event output; counting goes on whatever their state. When panic on uncorrected errors is enabled, an uncorrected report raises a sticky fatal output.

Top module: `memerr_count_bank`

## Requirements
- R1: A located report on channel c, slot s increments the counter of module m = c*NUM_SLOT + s for its type. The corrected counter of module m reads at address m and the uncorrected counter at address NMOD + m, where NMOD = NUM_CH*NUM_SLOT.
- R2: Every report adds one to the total of its type, whether or not it is located. The corrected total reads at NMOD*2+NUM_SLOT and the uncorrected total at the next address.
- R3: A report is located only when its location flag is 1 and both its channel and slot are in range. Any other report increments the no-info counter of its type (corrected at NMOD*2+NUM_SLOT+2, uncorrected at the next address) and leaves every per-module and coarse counter unchanged.
- R4: Coarse counter s reads at address NMOD*2+s and counts located reports of both types on slot s, from any channel.
- R5: Every event counter holds at 2^CNT_W-1 once it reaches it.
- R6: A clear strobe zeroes every counter on the next edge. When a clear and a report arrive in the same cycle, the counters end at zero.
- R7: The seconds counter, read at NMOD*2+NUM_SLOT+4, equals the number of clock edges since the last clear or reset divided by TICK_DIV, rounded down.
- R8: Counting does not depend on the log enables. One cycle after a report, log_evt_o is 1 if the enable for the report's type is set, and log_uncorr_o gives the report's type.
- R9: One cycle after an uncorrected report with panic enabled, fatal_o is 1. It stays at 1 until a clear strobe or reset. A clear in the same cycle as the report wins.
- R10: rd_data_o gives, one cycle after rd_addr_i, the addressed counter zero-extended. Addresses at or above NMOD*2+NUM_SLOT+5 read as zero.
- R11: After synchronous reset, every counter, log_evt_o, log_uncorr_o and fatal_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear strobe for all counters and the seconds count |
| evt_valid_i | input | 1 | An error report is present this cycle |
| evt_uncorr_i | input | 1 | 1 = uncorrected, 0 = corrected |
| evt_loc_ok_i | input | 1 | The report's channel and slot are meaningful |
| evt_ch_i | input | CH_W | Channel index of the report |
| evt_slot_i | input | SLOT_W | Module slot index within the channel |
| log_ce_en_i | input | 1 | Report corrected errors on the event output |
| log_ue_en_i | input | 1 | Report uncorrected errors on the event output |
| panic_ue_en_i | input | 1 | Raise fatal_o on an uncorrected error |
| rd_addr_i | input | ADDR_W | Counter read address |
| rd_data_o | output | TIME_W | Registered counter value |
| log_evt_o | output | 1 | One-cycle pulse for a logged report |
| log_uncorr_o | output | 1 | Type of the report behind the pulse |
| fatal_o | output | 1 | Sticky fatal indication |

## Verification
The bench builds the block with three channels of three slots, 4-bit event counters and a TICK_DIV of 8. With a counter ceiling of 15, saturation falls within a few dozen reports, so random traffic holds many counters at their limit while others still count. With eight cycles per tick the seconds counter steps often enough to check its value after clears. A channel and slot width of 2 bits lets the bench send out-of-range indices that must be treated as location-less.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

  // Classification of one incoming error report
  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_CE_LOC    = 3'd1,
    EV_UE_LOC    = 3'd2,
    EV_CE_NOINFO = 3'd3,
    EV_UE_NOINFO = 3'd4
  } evt_kind_e;

  function automatic logic is_noinfo(evt_kind_e k);
    return (k == EV_CE_NOINFO) || (k == EV_UE_NOINFO);
  endfunction

  function automatic logic is_located(evt_kind_e k);
    return (k == EV_CE_LOC) || (k == EV_UE_LOC);
  endfunction

endpackage

// File: rtl/memerr_evt_decode.sv
module memerr_evt_decode
  import memerr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  localparam int NMOD    = NUM_CH * NUM_SLOT,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int MOD_W   = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic              valid_i,
  input  logic              uncorr_i,
  input  logic              loc_ok_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [SLOT_W-1:0] slot_i,
  output evt_kind_e         kind_o,
  output logic [MOD_W-1:0]  mod_o
);

  logic in_range;

  always_comb begin
    in_range = (int'(ch_i) < NUM_CH) && (int'(slot_i) < NUM_SLOT);
    mod_o    = in_range ? MOD_W'(int'(ch_i) * NUM_SLOT + int'(slot_i)) : '0;
    if (!valid_i)
      kind_o = EV_NONE;
    else if (loc_ok_i && in_range)
      kind_o = uncorr_i ? EV_UE_LOC : EV_CE_LOC;
    else
      kind_o = uncorr_i ? EV_UE_NOINFO : EV_CE_NOINFO;
  end

endmodule

// File: rtl/memerr_sat_ctr.sv
module memerr_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      q_o <= '0;
    else if (inc_i && (q_o != MAXV))
      q_o <= q_o + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (q_o == MAXV && !clr_i) |=> (q_o == MAXV)); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(q_o)); // R5

endmodule

// File: rtl/memerr_sec_timer.sv
module memerr_sec_timer #(
  parameter int TICK_DIV = 100_000_000,
  parameter int TIME_W   = 32,
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  output logic [TIME_W-1:0] secs_o
);

  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [TIME_W-1:0] SEC_MAX  = '1;

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      div_q  <= '0;
      secs_o <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick && (secs_o != SEC_MAX))
        secs_o <= secs_o + 1'b1;
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(div_q) < TICK_DIV)); // R7

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (secs_o == $past(secs_o) || secs_o == $past(secs_o) + 1'b1)); // R7

  AST_SEC_RESTART: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (secs_o == '0)); // R6

endmodule

// File: rtl/memerr_count_bank.sv
module memerr_count_bank
  import memerr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int CNT_W    = 16,
  parameter int TIME_W   = 32,
  parameter int TICK_DIV = 100_000_000,
  localparam int NMOD    = NUM_CH * NUM_SLOT,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
  localparam int MOD_W   = (NMOD > 1) ? $clog2(NMOD) : 1,
  localparam int NUM_REG = 2 * NMOD + NUM_SLOT + 5,
  localparam int ADDR_W  = $clog2(NUM_REG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              evt_valid_i,
  input  logic              evt_uncorr_i,
  input  logic              evt_loc_ok_i,
  input  logic [CH_W-1:0]   evt_ch_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  input  logic              log_ce_en_i,
  input  logic              log_ue_en_i,
  input  logic              panic_ue_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [TIME_W-1:0] rd_data_o,
  output logic              log_evt_o,
  output logic              log_uncorr_o,
  output logic              fatal_o
);

  // Read address map
  localparam int A_MOD_UE = NMOD;
  localparam int A_COARSE = 2 * NMOD;
  localparam int A_TOT_CE = 2 * NMOD + NUM_SLOT;
  localparam int A_TOT_UE = A_TOT_CE + 1;
  localparam int A_NI_CE  = A_TOT_CE + 2;
  localparam int A_NI_UE  = A_TOT_CE + 3;
  localparam int A_SECS   = A_TOT_CE + 4;

  evt_kind_e        kind;
  logic [MOD_W-1:0] mod_idx;

  logic [CNT_W-1:0]  mod_ce_q [NMOD];
  logic [CNT_W-1:0]  mod_ue_q [NMOD];
  logic [CNT_W-1:0]  coarse_q [NUM_SLOT];
  logic [CNT_W-1:0]  tot_ce_q, tot_ue_q, ni_ce_q, ni_ue_q;
  logic [TIME_W-1:0] secs_q;
  logic [TIME_W-1:0] rd_nxt;

  memerr_evt_decode #(.NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT)) i_decode (
    .valid_i  (evt_valid_i),
    .uncorr_i (evt_uncorr_i),
    .loc_ok_i (evt_loc_ok_i),
    .ch_i     (evt_ch_i),
    .slot_i   (evt_slot_i),
    .kind_o   (kind),
    .mod_o    (mod_idx)
  );

  // Per-module counters, one pair for every channel/slot position
  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    memerr_sat_ctr #(.W(CNT_W)) i_ce (
      .clk(clk), .rst(rst), .clr_i(clr_i),
      .inc_i((kind == EV_CE_LOC) && (mod_idx == MOD_W'(m))),
      .q_o(mod_ce_q[m])
    );
    memerr_sat_ctr #(.W(CNT_W)) i_ue (
      .clk(clk), .rst(rst), .clr_i(clr_i),
      .inc_i((kind == EV_UE_LOC) && (mod_idx == MOD_W'(m))),
      .q_o(mod_ue_q[m])
    );

    AST_NOINFO_MOD: assert property (@(posedge clk) disable iff (rst)
      (is_noinfo(kind) && !clr_i) |=> ($stable(mod_ce_q[m]) && $stable(mod_ue_q[m]))); // R3
  end

  // Coarse bank: slot index only, all channels merged, both types
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_coarse
    memerr_sat_ctr #(.W(CNT_W)) i_cs (
      .clk(clk), .rst(rst), .clr_i(clr_i),
      .inc_i(is_located(kind) && (int'(evt_slot_i) == s)),
      .q_o(coarse_q[s])
    );

    AST_NOINFO_COARSE: assert property (@(posedge clk) disable iff (rst)
      (is_noinfo(kind) && !clr_i) |=> $stable(coarse_q[s])); // R3
  end

  memerr_sat_ctr #(.W(CNT_W)) i_tot_ce (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .inc_i((kind == EV_CE_LOC) || (kind == EV_CE_NOINFO)), .q_o(tot_ce_q));
  memerr_sat_ctr #(.W(CNT_W)) i_tot_ue (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .inc_i((kind == EV_UE_LOC) || (kind == EV_UE_NOINFO)), .q_o(tot_ue_q));
  memerr_sat_ctr #(.W(CNT_W)) i_ni_ce (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .inc_i(kind == EV_CE_NOINFO), .q_o(ni_ce_q));
  memerr_sat_ctr #(.W(CNT_W)) i_ni_ue (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .inc_i(kind == EV_UE_NOINFO), .q_o(ni_ue_q));

  memerr_sec_timer #(.TICK_DIV(TICK_DIV), .TIME_W(TIME_W)) i_timer (
    .clk(clk), .rst(rst), .clr_i(clr_i), .secs_o(secs_q));

  // Read multiplexer, registered at the port
  always_comb begin
    rd_nxt = '0;
    for (int m = 0; m < NMOD; m++) begin
      if (int'(rd_addr_i) == m)            rd_nxt = TIME_W'(mod_ce_q[m]);
      if (int'(rd_addr_i) == A_MOD_UE + m) rd_nxt = TIME_W'(mod_ue_q[m]);
    end
    for (int s = 0; s < NUM_SLOT; s++)
      if (int'(rd_addr_i) == A_COARSE + s) rd_nxt = TIME_W'(coarse_q[s]);
    if (int'(rd_addr_i) == A_TOT_CE) rd_nxt = TIME_W'(tot_ce_q);
    if (int'(rd_addr_i) == A_TOT_UE) rd_nxt = TIME_W'(tot_ue_q);
    if (int'(rd_addr_i) == A_NI_CE)  rd_nxt = TIME_W'(ni_ce_q);
    if (int'(rd_addr_i) == A_NI_UE)  rd_nxt = TIME_W'(ni_ue_q);
    if (int'(rd_addr_i) == A_SECS)   rd_nxt = secs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o    <= '0;
      log_evt_o    <= 1'b0;
      log_uncorr_o <= 1'b0;
      fatal_o      <= 1'b0;
    end else begin
      rd_data_o    <= rd_nxt;
      log_evt_o    <= evt_valid_i && (evt_uncorr_i ? log_ue_en_i : log_ce_en_i);
      log_uncorr_o <= evt_valid_i && evt_uncorr_i;
      if (clr_i)
        fatal_o <= 1'b0;
      else if (evt_valid_i && evt_uncorr_i && panic_ue_en_i)
        fatal_o <= 1'b1;
    end
  end

  AST_FATAL_SET: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_i && evt_uncorr_i && panic_ue_en_i && !clr_i) |=> fatal_o); // R9

  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fatal_o && !clr_i) |=> fatal_o); // R9

  AST_LOG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    log_evt_o |-> $past(evt_valid_i)); // R8

  AST_TOTAL_GE_NOINFO: assert property (@(posedge clk) disable iff (rst)
    (tot_ce_q >= ni_ce_q) && (tot_ue_q >= ni_ue_q)); // R2

endmodule

// File: tb/test_memerr_count_bank.sv
module test_memerr_count_bank;

  localparam int NUM_CH   = 3;
  localparam int NUM_SLOT = 3;
  localparam int CNT_W    = 4;
  localparam int TIME_W   = 16;
  localparam int TICK_DIV = 8;
  localparam int NMOD     = NUM_CH * NUM_SLOT;
  localparam int NUM_REG  = 2 * NMOD + NUM_SLOT + 5;
  localparam int ADDR_W   = $clog2(NUM_REG + 1);
  localparam int CMAX     = (1 << CNT_W) - 1;
  localparam int A_COARSE = 2 * NMOD;
  localparam int A_TOT_CE = 2 * NMOD + NUM_SLOT;
  localparam int A_SECS   = A_TOT_CE + 4;

  logic clk = 0;
  logic rst = 1;
  logic clr = 0;
  logic ev = 0, unc = 0, lok = 0;
  logic [1:0] ch = 0, sl = 0;
  logic lce = 0, lue = 0, pan = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic [TIME_W-1:0] rdata;
  logic log_evt, log_unc, fatal;

  always #2 clk = ~clk;

  memerr_count_bank #(
    .NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .CNT_W(CNT_W),
    .TIME_W(TIME_W), .TICK_DIV(TICK_DIV)
  ) i_memerr_count_bank (
    .clk(clk), .rst(rst), .clr_i(clr),
    .evt_valid_i(ev), .evt_uncorr_i(unc), .evt_loc_ok_i(lok),
    .evt_ch_i(ch), .evt_slot_i(sl),
    .log_ce_en_i(lce), .log_ue_en_i(lue), .panic_ue_en_i(pan),
    .rd_addr_i(addr), .rd_data_o(rdata),
    .log_evt_o(log_evt), .log_uncorr_o(log_unc), .fatal_o(fatal)
  );

  // Bench model
  int m_ce [NMOD];
  int m_ue [NMOD];
  int m_cs [NUM_SLOT];
  int m_tce, m_tue, m_nce, m_nue, m_cyc;
  bit m_fatal, m_log, m_logu;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int sinc(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic int exp_reg(int a);
    if (a < NMOD) return m_ce[a];
    if (a < 2 * NMOD) return m_ue[a - NMOD];
    if (a < A_TOT_CE) return m_cs[a - A_COARSE];
    case (a - A_TOT_CE)
      0: return m_tce;
      1: return m_tue;
      2: return m_nce;
      3: return m_nue;
      4: return m_cyc / TICK_DIV;
      default: return 0;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NMOD; i++) begin m_ce[i] = 0; m_ue[i] = 0; end
    for (int i = 0; i < NUM_SLOT; i++) m_cs[i] = 0;
    m_tce = 0; m_tue = 0; m_nce = 0; m_nue = 0; m_cyc = 0; m_fatal = 0;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock edge with the inputs currently driven; model follows
  task automatic step();
    bit located;
    int mi;
    @(posedge clk);
    m_log  = ev && (unc ? lue : lce);
    m_logu = ev && unc;
    if (rst) begin
      model_clear(); m_log = 0; m_logu = 0;
    end else if (clr) begin
      model_clear();
    end else begin
      m_cyc++;
      if (ev) begin
        located = lok && (ch < NUM_CH) && (sl < NUM_SLOT);
        mi = ch * NUM_SLOT + sl;
        if (unc) m_tue = sinc(m_tue); else m_tce = sinc(m_tce);
        if (located) begin
          if (unc) m_ue[mi] = sinc(m_ue[mi]); else m_ce[mi] = sinc(m_ce[mi]);
          m_cs[sl] = sinc(m_cs[sl]);
        end else begin
          if (unc) m_nue = sinc(m_nue); else m_nce = sinc(m_nce);
        end
        if (unc && pan) m_fatal = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ev = 0; clr = 0;
  endtask

  task automatic send(bit u, bit l, int c, int s);
    ev = 1; unc = u; lok = l; ch = 2'(c); sl = 2'(s);
    step();
    ev = 0;
  endtask

  task automatic read_chk(string req, int a);
    int e;
    addr = ADDR_W'(a);
    e = exp_reg(a);
    step();
    check(req, int'(rdata), e);
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < (1 << ADDR_W); a++) read_chk(req, a);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_clear();
    @(negedge clk);
    step(); step();
    rst = 0;
    // R11: reset state
    check("R11 log_evt", log_evt, 0);
    check("R11 fatal", fatal, 0);
    read_all("R11 counters after reset");

    // R1: located corrected and uncorrected on channel 2 slot 1 (module 7)
    lce = 1; lue = 0;
    send(0, 1, 2, 1);
    check("R8 log corrected enabled", log_evt, 1);
    check("R8 log type", log_unc, 0);
    send(1, 1, 2, 1);
    check("R8 log uncorrected disabled", log_evt, 0);
    check("R8 log type uncorr", log_unc, 1);
    read_chk("R1 module 7 corrected", 7);
    read_chk("R1 module 7 uncorrected", NMOD + 7);
    read_chk("R2 total corrected", A_TOT_CE);
    read_chk("R2 total uncorrected", A_TOT_CE + 1);

    // R3: no-info reports: flag low, and out-of-range channel/slot
    send(0, 0, 1, 1);
    send(1, 1, 3, 0);
    send(0, 1, 0, 3);
    read_chk("R3 no-info corrected", A_TOT_CE + 2);
    read_chk("R3 no-info uncorrected", A_TOT_CE + 3);
    read_chk("R3 module 4 untouched", 4);
    read_chk("R3 coarse slot 0 untouched", A_COARSE);
    read_chk("R2 total includes no-info", A_TOT_CE);

    // R4: coarse bank merges channels
    send(0, 1, 0, 2);
    send(1, 1, 1, 2);
    send(0, 1, 2, 2);
    read_chk("R4 coarse slot 2", A_COARSE + 2);
    read_chk("R4 coarse slot 1", A_COARSE + 1);

    // R5: saturation on module 0
    for (int i = 0; i < CMAX + 5; i++) send(0, 1, 0, 0);
    read_chk("R5 module 0 saturated", 0);
    check("R5 model at max", exp_reg(0), CMAX);
    read_chk("R5 total saturated", A_TOT_CE);

    // R9: panic
    pan = 1;
    send(1, 1, 0, 1);
    check("R9 fatal set", fatal, 1);
    pan = 0;
    idle(); step();
    check("R9 fatal held", fatal, 1);

    // R6: clear together with an event and panic
    pan = 1; clr = 1;
    send(1, 1, 1, 1);
    clr = 0; pan = 0;
    check("R6 R9 clear wins over fatal", fatal, 0);
    read_all("R6 all zero after clear");

    // R7: seconds after clear
    clr = 1; step(); clr = 0;
    for (int i = 0; i < 20; i++) step();
    read_chk("R7 seconds", A_SECS);
    read_chk("R7 seconds later", A_SECS);

    // R10: out-of-range address
    read_chk("R10 out-of-range read", NUM_REG);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      ev  = ($urandom % 4) != 0;
      unc = $urandom % 2;
      lok = ($urandom % 5) != 0;
      ch  = 2'($urandom % 4);
      sl  = 2'($urandom % 4);
      lce = $urandom % 2;
      lue = $urandom % 2;
      pan = ($urandom % 16) == 0;
      clr = ($urandom % 400) == 0;
      step();
      check("R8 random log_evt", log_evt, m_log);
      check("R8 random log type", log_unc, m_logu);
      check("R9 random fatal", fatal, m_fatal);
      if ((i % 300) == 299) begin
        idle();
        read_all("R1 R2 R3 R4 R5 R7 random readback");
      end
    end
    idle();
    read_all("R10 final readback");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule